// File: doc/BRIEF.md
# Successive Approximation Control Register

This block is the digital half of a successive approximation converter. It holds a parallel result word and steps one trial bit at a time from the most significant position down to the least. An external comparator reports through a serial input whether the value under trial was too large. The bit under trial is driven low and every undecided bit below it sits high. On each clock the comparator decision is written into the trial position, and the next lower position becomes the new trial bit.

Each decision is also shown on a serial output. An active-low completion flag falls on the clock edge that decides the last bit. A conversion runs either once per low pulse on the start input, or continuously when the completion flag is wired back to the start input. An active-high enable-bar input freezes the sequence. While it is high, the top output is forced high, so several registers can be chained or one can be cut short.

Top module: `sar_ctrl`

## Requirements
- R1: On a clock edge with `rst` high, `par_q` becomes all ones, `done_n` becomes 0 and `ser_q` becomes 0. The block then stays idle until a start is seen.
- R2: On an edge with `rst` low, `en_n` low and `start_n` low, `par_q` becomes the MSB at 0 with all lower bits at 1, and `done_n` becomes 1.
- R3: On an edge with `en_n` low, `start_n` high and a conversion in progress, `cmp_in` is written into the current trial bit. The next lower bit (if any) is driven to 0, and the bits below it keep the value 1.
- R4: On every capture edge, `ser_q` takes the value of the bit just decided.
- R5: `done_n` stays 1 through the conversion and falls on the edge that captures bit 0. That edge is the WIDTH-th edge after the start edge, so it is the (WIDTH+1)-th clock counting the start.
- R6: Once `done_n` is 0, further edges with `start_n` high leave `par_q`, `ser_q` and `done_n` unchanged.
- R7: On an edge with `en_n` high, `start_n` and `cmp_in` are ignored. `par_q[WIDTH-1]` becomes 1, all other outputs and the trial position keep their values, and the conversion resumes from that position once `en_n` returns low.
- R8: A low `start_n` in the middle of a conversion aborts it and reinitialises the register as in R2 on that same edge.
- R9: With `start_n` tied to `done_n`, a new conversion begins on the edge after each completion, with no other stimulus.
- R10: With a comparator that returns 1 when the trial value (decided bits, trial bit at 1, rest 0) does not exceed a code, `par_q` equals that code on the WIDTH-th edge after the start edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| start_n | input | 1 | Begin conversion, active low |
| en_n | input | 1 | Enable, active low; high freezes the block and forces the MSB high |
| cmp_in | input | 1 | Comparator decision for the current trial bit |
| par_q | output | WIDTH | Parallel result and trial word |
| ser_q | output | 1 | Most recently decided bit |
| done_n | output | 1 | Conversion complete, active low |

## Verification
The bench converts all-zero, all-ones, alternating and two arbitrary codes. These codes show whether each decision lands in its own position and whether the trial pattern moves one step per clock. Enable is raised partway through a conversion to check that the trial position holds while the MSB is forced high and that the conversion resumes. A second start is pulsed mid-conversion to check the abort. In the continuous run, completion is fed back to start, which shows whether the edges back to back restart cleanly. A cycle model is compared against all three outputs on every clock.

// File: rtl/sar_ctrl.sv
module sar_ctrl #(
  parameter int WIDTH = 12
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start_n,
  input  logic             en_n,
  input  logic             cmp_in,
  output logic [WIDTH-1:0] par_q,
  output logic             ser_q,
  output logic             done_n
);
  localparam int IW = (WIDTH > 1) ? $clog2(WIDTH) : 1;
  localparam logic [IW-1:0] TOP = IW'(WIDTH - 1);

  logic [IW-1:0] trial;

  always_ff @(posedge clk) begin
    if (rst) begin
      par_q  <= '1;
      done_n <= 1'b0;
      ser_q  <= 1'b0;
      trial  <= '0;
    end else if (en_n) begin
      par_q[WIDTH-1] <= 1'b1;
    end else if (!start_n) begin
      par_q  <= {1'b0, {(WIDTH-1){1'b1}}};
      done_n <= 1'b1;
      trial  <= TOP;
    end else if (done_n) begin
      par_q[trial] <= cmp_in;
      ser_q        <= cmp_in;
      if (trial == '0) begin
        done_n <= 1'b0;
      end else begin
        par_q[trial - 1'b1] <= 1'b0;
        trial               <= trial - 1'b1;
      end
    end
  end
endmodule

module sar_ctrl_chk #(
  parameter int WIDTH = 12
) (
  input logic             clk,
  input logic             rst,
  input logic             start_n,
  input logic             en_n,
  input logic             cmp_in,
  input logic [WIDTH-1:0] par_q,
  input logic             ser_q,
  input logic             done_n
);
  // R1
  reset_idle_chk: assert property (@(posedge clk)
    rst |=> (par_q == '1 && !done_n && !ser_q));

  // R2
  start_init_chk: assert property (@(posedge clk) disable iff (rst)
    (!en_n && !start_n) |=> (par_q == {1'b0, {(WIDTH-1){1'b1}}} && done_n));

  // R4
  serial_echo_chk: assert property (@(posedge clk) disable iff (rst)
    (!en_n && start_n && done_n) |=> (ser_q == $past(cmp_in)));

  // R5
  done_on_lsb_chk: assert property (@(posedge clk) disable iff (rst)
    (!en_n && start_n && done_n) |=> (done_n || (par_q[0] == ser_q)));

  // R6
  hold_after_done_chk: assert property (@(posedge clk) disable iff (rst)
    (!en_n && start_n && !done_n) |=> ($stable(par_q) && $stable(ser_q) && !done_n));

  // R7
  enable_freeze_chk: assert property (@(posedge clk) disable iff (rst)
    en_n |=> (par_q[WIDTH-1] && $stable(par_q[WIDTH-2:0]) && $stable(done_n) && $stable(ser_q)));
endmodule

bind sar_ctrl sar_ctrl_chk #(.WIDTH(WIDTH)) u_chk (.*);

// File: tb/sar_ctrl_bench.sv
module sar_ctrl_bench;
  localparam int W = 12;

  logic clk = 0;
  logic rst = 1;
  logic start_drv = 1;
  logic en_n = 0;
  logic cmp_in = 0;
  logic cont = 0;
  logic start_n;
  logic [W-1:0] par_q;
  logic ser_q, done_n;

  assign start_n = cont ? done_n : start_drv;

  always #4 clk = ~clk;

  sar_ctrl #(.WIDTH(W)) u_sar_ctrl (
    .clk(clk), .rst(rst), .start_n(start_n), .en_n(en_n), .cmp_in(cmp_in),
    .par_q(par_q), .ser_q(ser_q), .done_n(done_n)
  );

  int runs = 0;
  int fails = 0;
  bit m_q[W];
  bit m_done, m_ser;
  int m_pos;
  logic [W-1:0] code = '0;

  function automatic logic [W-1:0] model_word();
    logic [W-1:0] v;
    for (int i = 0; i < W; i++) v[i] = m_q[i];
    return v;
  endfunction

  task automatic check(input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
    runs++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic model_step(input bit r, input bit en, input bit st, input bit c);
    if (r) begin
      for (int i = 0; i < W; i++) m_q[i] = 1;
      m_done = 0; m_ser = 0; m_pos = 0;
    end else if (en) begin
      m_q[W-1] = 1;
    end else if (!st) begin
      for (int i = 0; i < W; i++) m_q[i] = (i != W-1);
      m_done = 1; m_pos = W-1;
    end else if (m_done) begin
      m_q[m_pos] = c; m_ser = c;
      if (m_pos == 0) m_done = 0;
      else begin m_q[m_pos-1] = 0; m_pos--; end
    end
  endtask

  function automatic bit comparator();
    logic [W-1:0] cand;
    cand = '0;
    for (int i = W-1; i > m_pos; i--) cand[i] = m_q[i];
    cand[m_pos] = 1'b1;
    return (cand <= code);
  endfunction

  task automatic step(input string req);
    bit r, e, s, c;
    cmp_in = (m_done && m_pos >= 0) ? comparator() : 1'b0;
    r = rst; e = en_n; c = cmp_in;
    s = cont ? m_done : start_drv;
    @(posedge clk);
    model_step(r, e, s, c);
    @(negedge clk);
    check({req, " par_q"}, par_q, model_word());
    check({req, " ser_q"}, W'(ser_q), W'(m_ser));
    check({req, " done_n"}, W'(done_n), W'(m_done));
  endtask

  task automatic convert(input logic [W-1:0] val, input string tag);
    code = val;
    start_drv = 0; step("R2 start");
    check("R2 init word", par_q, {1'b0, {(W-1){1'b1}}});
    start_drv = 1;
    for (int k = 1; k < W; k++) step("R3 capture");
    check("R5 done still high", W'(done_n), W'(1'b1));
    step("R5 lsb");
    check({"R10 result ", tag}, par_q, val);
    check("R5 done low", W'(done_n), W'(1'b0));
    check("R4 lsb echo", W'(ser_q), W'(val[0]));
    step("R6 hold");
    step("R6 hold");
    check("R6 word held", par_q, val);
  endtask

  initial begin
    int n;
    n = 0;
    while (n < 150000) begin @(posedge clk); n++; end
    fails++; runs++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("  [TB] %0d tests run, %0d failed", runs, fails);
    $finish;
  end

  initial begin
    @(negedge clk);
    rst = 1; step("R1 reset");
    step("R1 reset");
    rst = 0;
    check("R1 idle word", par_q, '1);
    check("R1 idle done", W'(done_n), W'(1'b0));
    step("R1 idle");
    check("R1 stays idle", par_q, '1);

    convert(12'h000, "zero");
    convert(12'hFFF, "ones");
    convert(12'hA5A, "alt");
    convert(12'h3C7, "mix");
    convert(12'h801, "edge");

    code = 12'h6B2;
    start_drv = 0; step("R2 start");
    start_drv = 1;
    for (int k = 0; k < 4; k++) step("R3 capture");
    en_n = 1;
    start_drv = 0;
    step("R7 freeze");
    check("R7 msb forced", W'(par_q[W-1]), W'(1'b1));
    check("R7 done unchanged", W'(done_n), W'(1'b1));
    step("R7 freeze");
    start_drv = 1; en_n = 0;
    for (int k = 0; k < 8; k++) step("R7 resume");
    check("R7 done after resume", W'(done_n), W'(1'b0));

    code = 12'h159;
    start_drv = 0; step("R2 start");
    start_drv = 1;
    for (int k = 0; k < 5; k++) step("R3 capture");
    start_drv = 0; step("R8 abort");
    check("R8 reinit", par_q, {1'b0, {(W-1){1'b1}}});
    start_drv = 1;
    for (int k = 0; k < W; k++) step("R8 rerun");
    check("R8 result", par_q, 12'h159);

    code = 12'h2E4;
    cont = 1;
    for (int k = 0; k < 3 * (W + 1); k++) step("R9 continuous");
    check("R9 done low at cycle end", W'(done_n), W'(1'b0));
    check("R9 result", par_q, 12'h2E4);
    step("R9 restart");
    check("R9 restarted", par_q, {1'b0, {(W-1){1'b1}}});
    cont = 0;

    $display("  [TB] %0d tests run, %0d failed", runs, fails);
    $finish;
  end
endmodule